// File: doc/BRIEF.md
# Supervisory Audio Tone Unit

This block handles the supervisory audio tone of an analog cellular voice channel. On the transmit side a phase accumulator makes a square wave at one of three closely spaced tones near 6 kHz (5970 Hz, 6000 Hz, 6030 Hz). A loopback switch can instead route the received tone, after a two-flop synchroniser, straight back to the transmit pin. On the receive side a detector times sixteen consecutive periods of the sliced tone and decides which of the three tones is present, or that none is.

The detector is a three-state machine. IDLE waits for a first rising edge (transition IDLE→MEASURE on that edge). MEASURE counts clocks and rising edges; on the sixteenth edge after the window start it takes MEASURE→JUDGE, and if no edge comes for twice the longest nominal period it takes MEASURE→IDLE (timeout) and reports no tone. JUDGE lasts one cycle, classifies the latched sum, and always takes JUDGE→MEASURE, so windows run back to back while the tone persists. A change of the reported tone code sets an interrupt flag that software clears by writing one.

Timing assumes the core clock is the 8.064 MHz master clock; all tone constants are derived from parameters.

Top module: `sat_tone_unit`

## Requirements
- R1: After reset the tone code is 00, the valid bit and interrupt are 0, the transmit output is 0 and the control register (address 0) reads 0.
- R2: With the tone select field (control bits [1:0]) at 00 and loopback (control bit 2) off, the transmit output stays low.
- R3: Tone select 01, 10 and 11 make a square wave whose period averages 8064000/f clocks for f = 5970, 6000 and 6030 Hz respectively.
- R4: With loopback set, the transmit output equals the receive input as sampled two clock edges earlier, whatever the tone select.
- R5: Over a window of 16 receive periods the summed length in clocks is classified: [21344, 21450) gives code 11 (6030 Hz), [21450, 21558) gives 10 (6000 Hz), [21558, 21666] gives 01 (5970 Hz); status bits [1:0] carry the code and bit 2 is 1 whenever the code is non-zero.
- R6: A window sum outside [21344, 21666] gives code 00.
- R7: If no rising edge arrives for 2702 clocks the code becomes 00 and the detector waits for a fresh first edge.
- R8: Every change of the tone code, including loss of tone, sets the interrupt output and status bit 3.
- R9: Writing status (address 1) with bit 3 at one clears the interrupt; a change in the same cycle wins.
- R10: Back-to-back windows that give the same code raise no further interrupt and leave the code unchanged.
- R11: The control register reads back the value written to its bits [2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 8.064 MHz nominal |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sat_in | input | 1 | Sliced receive tone, asynchronous |
| tx_sat_out | output | 1 | Transmit tone output |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control, 1 = status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| sat_code | output | 2 | Detected tone code |
| sat_valid | output | 1 | A tone is detected |
| sat_irq | output | 1 | Tone code changed, pending clear |

## Verification
A wrong window sum or a misplaced boundary shows as a wrong code on the interrupt that follows the sixteenth edge, about 21,500 clocks after a tone starts, and the scoreboard compares each interrupt with the code queued by the stimulus. A stuck or miscounted timeout shows 2702 clocks after the last edge as a missing or early loss-of-tone interrupt. A spurious code change, for instance on an out-of-window tone or a repeat window, appears at once as an interrupt with nothing queued. Accumulator increment errors appear within eight transmit periods as a period sum off by more than a few clocks.

// File: rtl/sat_pkg.sv
package sat_pkg;

    typedef enum logic [1:0] {
        SAT_NONE  = 2'b00,
        SAT_F5970 = 2'b01,
        SAT_F6000 = 2'b10,
        SAT_F6030 = 2'b11
    } sat_code_e;

    typedef enum logic [1:0] {
        DET_IDLE    = 2'b00,
        DET_MEASURE = 2'b01,
        DET_JUDGE   = 2'b10
    } det_state_e;

    localparam int CTRL_W = 3;

    // Phase step for a tone of freq_hz with a 2^acc_w accumulator, rounded.
    function automatic longint tone_step(longint freq_hz, longint clk_hz, int acc_w);
        return ((freq_hz << acc_w) + clk_hz / 2) / clk_hz;
    endfunction

endpackage

// File: rtl/sat_tone_gen.sv
module sat_tone_gen
    import sat_pkg::*;
#(
    parameter int     ACC_W  = 24,
    parameter longint CLK_HZ = 8064000,
    parameter longint F_LO   = 5970,
    parameter longint F_MID  = 6000,
    parameter longint F_HI   = 6030
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    output logic       tone_out
);

    localparam int NTONE = 3;
    localparam longint FREQS [NTONE] = '{F_LO, F_MID, F_HI};

    logic [ACC_W-1:0] step_tab [NTONE];
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] acc;

    genvar gi;
    generate
        for (gi = 0; gi < NTONE; gi++) begin : g_step
            assign step_tab[gi] = ACC_W'(tone_step(FREQS[gi], CLK_HZ, ACC_W));
        end
    endgenerate

    always_comb begin
        unique case (sel)
            2'b01:   step = step_tab[0];
            2'b10:   step = step_tab[1];
            2'b11:   step = step_tab[2];
            default: step = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (sel == 2'b00) begin
            acc <= '0;
        end else begin
            acc <= acc + step;
        end
    end

    assign tone_out = acc[ACC_W-1];

    // R2: a deselected generator returns to phase zero
    assert_acc_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b00) |=> (acc == '0));

    // R3: while a tone is selected and held, the phase advances every cycle
    assert_phase_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != 2'b00 && $past(sel) == sel) |-> (acc != $past(acc)));

endmodule

// File: rtl/sat_tone_det.sv
module sat_tone_det
    import sat_pkg::*;
#(
    parameter longint CLK_HZ   = 8064000,
    parameter longint F_LO     = 5970,
    parameter longint F_MID    = 6000,
    parameter longint F_HI     = 6030,
    parameter int     AVG_LOG2 = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      edge_pulse,
    output sat_code_e code,
    output logic      changed
);

    localparam longint EDGES    = longint'(1) << AVG_LOG2;
    localparam longint SUM_LO   = EDGES * CLK_HZ / F_LO;
    localparam longint SUM_MID  = EDGES * CLK_HZ / F_MID;
    localparam longint SUM_HI   = EDGES * CLK_HZ / F_HI;
    localparam longint B_MIN    = SUM_HI - (SUM_MID - SUM_HI) / 2;
    localparam longint B_A      = (SUM_HI + SUM_MID) / 2;
    localparam longint B_B      = (SUM_MID + SUM_LO) / 2;
    localparam longint B_MAX    = SUM_LO + (SUM_LO - SUM_MID) / 2;
    localparam longint TIMEOUT  = 2 * ((CLK_HZ + F_LO - 1) / F_LO);
    localparam int     SUM_W    = $clog2(EDGES * TIMEOUT + 2);
    localparam int     CNT_W    = $clog2(TIMEOUT + 1);

    localparam logic [SUM_W-1:0] LIM_MIN = SUM_W'(B_MIN);
    localparam logic [SUM_W-1:0] LIM_A   = SUM_W'(B_A);
    localparam logic [SUM_W-1:0] LIM_B   = SUM_W'(B_B);
    localparam logic [SUM_W-1:0] LIM_MAX = SUM_W'(B_MAX);
    localparam logic [CNT_W-1:0] TMO_V   = CNT_W'(TIMEOUT);

    det_state_e          state, state_nx;
    logic [SUM_W-1:0]    sum;
    logic [SUM_W-1:0]    total;
    logic [CNT_W-1:0]    idle_cnt;
    logic [AVG_LOG2-1:0] edge_cnt;
    logic                last_edge;
    logic                timeout;
    sat_code_e           verdict;
    sat_code_e           code_nx;

    assign last_edge = edge_pulse && (edge_cnt == '1);
    assign timeout   = (idle_cnt == TMO_V) && !edge_pulse;

    // Window classification of the latched period sum
    always_comb begin
        if (total < LIM_MIN || total > LIM_MAX) begin
            verdict = SAT_NONE;
        end else if (total < LIM_A) begin
            verdict = SAT_F6030;
        end else if (total < LIM_B) begin
            verdict = SAT_F6000;
        end else begin
            verdict = SAT_F5970;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            DET_IDLE: begin
                if (edge_pulse) state_nx = DET_MEASURE;
            end
            DET_MEASURE: begin
                if (timeout)        state_nx = DET_IDLE;
                else if (last_edge) state_nx = DET_JUDGE;
            end
            DET_JUDGE: begin
                if (timeout) state_nx = DET_IDLE;
                else         state_nx = DET_MEASURE;
            end
            default: state_nx = DET_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DET_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        code_nx = code;
        if (state != DET_IDLE && timeout) begin
            code_nx = SAT_NONE;
        end else if (state == DET_JUDGE) begin
            code_nx = verdict;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum      <= '0;
            total    <= '0;
            idle_cnt <= '0;
            edge_cnt <= '0;
            code     <= SAT_NONE;
            changed  <= 1'b0;
        end else begin
            code    <= code_nx;
            changed <= (code_nx != code);
            unique case (state)
                DET_IDLE: begin
                    sum      <= '0;
                    idle_cnt <= '0;
                    edge_cnt <= '0;
                end
                DET_MEASURE, DET_JUDGE: begin
                    if (timeout) begin
                        sum      <= '0;
                        idle_cnt <= '0;
                        edge_cnt <= '0;
                    end else begin
                        if (last_edge) begin
                            total <= sum + 1'b1;
                            sum   <= '0;
                        end else begin
                            sum <= sum + 1'b1;
                        end
                        if (edge_pulse) begin
                            idle_cnt <= '0;
                            edge_cnt <= edge_cnt + 1'b1;
                        end else begin
                            idle_cnt <= idle_cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    sum      <= '0;
                    idle_cnt <= '0;
                    edge_cnt <= '0;
                end
            endcase
        end
    end

    // R5: a verdict is only taken straight after a measuring cycle
    assert_judge_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DET_JUDGE) |-> ($past(state) == DET_MEASURE));

    // R6: a sum outside every window yields no tone
    assert_out_of_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DET_JUDGE && (total < LIM_MIN || total > LIM_MAX)) |=> (code == SAT_NONE));

    // R7: silence for the timeout span drops the code and re-arms
    assert_timeout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != DET_IDLE && idle_cnt == TMO_V && !edge_pulse)
            |=> (state == DET_IDLE && code == SAT_NONE));

    // R8: the change pulse only follows a real code change
    assert_change_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        changed |-> (code != $past(code)));

    // R10: the code moves only on a verdict or a timeout
    assert_code_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |-> ($past(state) == DET_JUDGE || $past(idle_cnt) == TMO_V));

endmodule

// File: rtl/sat_ctrl_regs.sv
module sat_ctrl_regs
    import sat_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic       addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  sat_code_e  code,
    input  logic       changed,
    output logic [1:0] sel,
    output logic       loop_en,
    output logic       irq
);

    logic [CTRL_W-1:0] ctrl_q;
    logic              valid;
    logic              clr_req;

    assign valid   = (code != SAT_NONE);
    assign clr_req = wr && addr && wdata[3];
    assign sel     = ctrl_q[1:0];
    assign loop_en = ctrl_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr && !addr) begin
            ctrl_q <= wdata[CTRL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (changed) begin
            irq <= 1'b1;
        end else if (clr_req) begin
            irq <= 1'b0;
        end
    end

    always_comb begin
        if (addr) rdata = {4'b0000, irq, valid, code};
        else      rdata = {{(8-CTRL_W){1'b0}}, ctrl_q};
    end

    // R8: a code change leaves the interrupt pending
    assert_irq_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        changed |=> irq);

    // R9: a clear with no competing change drops the interrupt
    assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !changed) |=> !irq);

endmodule

// File: rtl/sat_tone_unit.sv
module sat_tone_unit
    import sat_pkg::*;
#(
    parameter longint CLK_HZ   = 8064000,
    parameter longint F_LO     = 5970,
    parameter longint F_MID    = 6000,
    parameter longint F_HI     = 6030,
    parameter int     ACC_W    = 24,
    parameter int     AVG_LOG2 = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_sat_in,
    output logic       tx_sat_out,
    input  logic       reg_wr,
    input  logic       reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [1:0] sat_code,
    output logic       sat_valid,
    output logic       sat_irq
);

    logic      rx_s1, rx_s2, rx_s3;
    logic      rx_rise;
    logic [1:0] sel;
    logic      loop_en;
    logic      gen_tone;
    sat_code_e code;
    logic      changed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_s1 <= 1'b0;
            rx_s2 <= 1'b0;
            rx_s3 <= 1'b0;
        end else begin
            rx_s1 <= rx_sat_in;
            rx_s2 <= rx_s1;
            rx_s3 <= rx_s2;
        end
    end

    assign rx_rise = rx_s2 && !rx_s3;

    sat_ctrl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .code    (code),
        .changed (changed),
        .sel     (sel),
        .loop_en (loop_en),
        .irq     (sat_irq)
    );

    sat_tone_gen #(
        .ACC_W  (ACC_W),
        .CLK_HZ (CLK_HZ),
        .F_LO   (F_LO),
        .F_MID  (F_MID),
        .F_HI   (F_HI)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .tone_out (gen_tone)
    );

    sat_tone_det #(
        .CLK_HZ   (CLK_HZ),
        .F_LO     (F_LO),
        .F_MID    (F_MID),
        .F_HI     (F_HI),
        .AVG_LOG2 (AVG_LOG2)
    ) u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_pulse (rx_rise),
        .code       (code),
        .changed    (changed)
    );

    // Transmit mux: loopback of the synchronised receive tone or the generator
    always_comb begin
        if (loop_en)           tx_sat_out = rx_s2;
        else if (sel == 2'b00) tx_sat_out = 1'b0;
        else                   tx_sat_out = gen_tone;
    end

    assign sat_code  = code;
    assign sat_valid = (code != SAT_NONE);

    // R2: deselected and not looping means a silent transmit pin
    assert_tx_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!loop_en && sel == 2'b00) |-> !tx_sat_out);

    // R4: loopback follows the receive path one stage behind the first flop
    assert_loop_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (tx_sat_out == $past(rx_s1)));

endmodule

// File: tb/tb_sat_tone_unit.sv
module tb_sat_tone_unit;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_sat_in;
    logic       tx_sat_out;
    logic       reg_wr;
    logic       reg_addr;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic [1:0] sat_code;
    logic       sat_valid;
    logic       sat_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [1:0] exp_code_q [$];
    string      exp_tag_q  [$];

    always #4 clk = ~clk;

    sat_tone_unit dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_sat_in  (rx_sat_in),
        .tx_sat_out (tx_sat_out),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .sat_code   (sat_code),
        .sat_valid  (sat_valid),
        .sat_irq    (sat_irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
        reg_addr  = 1'b0;
        reg_wdata = 8'h00;
    endtask

    task automatic drive_tone(input int period, input int n);
        for (int k = 0; k < n; k++) begin
            rx_sat_in = 1'b1;
            repeat (period / 2) @(negedge clk);
            rx_sat_in = 1'b0;
            repeat (period - period / 2) @(negedge clk);
        end
    endtask

    // Measures eight transmit periods and compares with 8*CLK/f
    task automatic measure_tx(input real freq, input string req);
        logic prev;
        int   rises;
        int   cycles;
        real  expv;
        prev = tx_sat_out;
        while (!(prev == 1'b0 && tx_sat_out == 1'b1)) begin
            prev = tx_sat_out;
            @(negedge clk);
        end
        rises  = 0;
        cycles = 0;
        prev   = tx_sat_out;
        while (rises < 8) begin
            @(negedge clk);
            cycles++;
            if (!prev && tx_sat_out) rises++;
            prev = tx_sat_out;
        end
        expv = 8.0 * 8064000.0 / freq;
        check((cycles > expv - 3.0) && (cycles < expv + 3.0), req,
              "tx eight-period length", cycles, longint'(expv));
    endtask

    // Driver: one tone, queue its expected code, then silence and queue loss
    task automatic run_tone(input logic [1:0] sel, input int period,
                            input real freq, input logic [1:0] code);
        reg_write(1'b0, {6'b0, sel});
        exp_code_q.push_back(code);
        exp_tag_q.push_back("R5");
        fork
            drive_tone(period, 17);
            measure_tx(freq, "R3");
        join
        exp_code_q.push_back(2'b00);
        exp_tag_q.push_back("R7");
        repeat (3000) @(negedge clk);
    endtask

    // Monitor: every interrupt is scored against the queue, then cleared
    initial begin
        logic [1:0] ec;
        string      tg;
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (sat_irq) begin
                if (exp_code_q.size() == 0) begin
                    check(1'b0, "R10", "unexpected interrupt code", sat_code, 0);
                end else begin
                    ec = exp_code_q.pop_front();
                    tg = exp_tag_q.pop_front();
                    check(sat_code == ec, tg, "code on interrupt (R8)", sat_code, ec);
                    check(sat_valid == (ec != 2'b00), "R5", "valid bit", sat_valid, ec != 2'b00);
                end
                reg_write(1'b1, 8'h08);
                check(sat_irq == 1'b0, "R9", "interrupt after write-one clear", sat_irq, 0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit low_ok;
        rst_n     = 1'b0;
        rx_sat_in = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = 1'b0;
        reg_wdata = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(tx_sat_out == 1'b0, "R1", "tx after reset", tx_sat_out, 0);
        check(sat_code == 2'b00, "R1", "code after reset", sat_code, 0);
        check(sat_valid == 1'b0, "R1", "valid after reset", sat_valid, 0);
        check(sat_irq == 1'b0, "R1", "irq after reset", sat_irq, 0);
        check(reg_rdata == 8'h00, "R1", "control after reset", reg_rdata, 0);

        // R2 silent transmit with nothing selected
        low_ok = 1'b1;
        repeat (200) begin
            @(negedge clk);
            if (tx_sat_out) low_ok = 1'b0;
        end
        check(low_ok, "R2", "tx stays low when off", !low_ok, 0);

        // R11 readback, and R4 loopback over a selected tone
        reg_write(1'b0, 8'h07);
        check(reg_rdata == 8'h07, "R11", "control readback", reg_rdata, 7);
        rx_sat_in = 1'b1;
        repeat (2) @(negedge clk);
        check(tx_sat_out == 1'b1, "R4", "loopback high", tx_sat_out, 1);
        repeat (10) @(negedge clk);
        rx_sat_in = 1'b0;
        repeat (2) @(negedge clk);
        check(tx_sat_out == 1'b0, "R4", "loopback low", tx_sat_out, 0);
        reg_write(1'b0, 8'h00);
        repeat (3000) @(negedge clk);

        // R5 / R3: each tone on both paths, R7 loss after each
        run_tone(2'b10, 1344, 6000.0, 2'b10);
        run_tone(2'b11, 1337, 6030.0, 2'b11);
        run_tone(2'b01, 1351, 5970.0, 2'b01);

        // R6: a tone well outside every window reports nothing
        reg_write(1'b0, 8'h00);
        drive_tone(1300, 18);
        repeat (3000) @(negedge clk);
        check(sat_code == 2'b00, "R6", "code for out-of-window tone", sat_code, 0);
        check(exp_code_q.size() == 0, "R6", "pending expectations", exp_code_q.size(), 0);

        // R10: two consecutive matching windows, one interrupt only
        exp_code_q.push_back(2'b10);
        exp_tag_q.push_back("R5");
        drive_tone(1344, 34);
        check(sat_code == 2'b10, "R10", "code held over second window", sat_code, 2);
        check(sat_irq == 1'b0, "R10", "no interrupt on repeat window", sat_irq, 0);
        exp_code_q.push_back(2'b00);
        exp_tag_q.push_back("R7");
        repeat (3000) @(negedge clk);

        // R2 again after the generator has run
        low_ok = 1'b1;
        repeat (500) begin
            @(negedge clk);
            if (tx_sat_out) low_ok = 1'b0;
        end
        check(low_ok, "R2", "tx low after deselect", !low_ok, 0);
        check(exp_code_q.size() == 0, "R8", "unserved expected interrupts", exp_code_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule